// File: doc/BRIEF.md
# Fetch-Side Branch Direction and Target Predictor

This block sits beside the instruction fetch stage and guesses where fetch goes next. A small direct-mapped table is indexed by the low bits of the fetch address. Each slot holds a valid flag, the remaining upper address bits as a tag, a two-bit saturating confidence counter and the target address the branch jumped to. The target is stored already computed, so a branch predicted taken can steer fetch in the same cycle it is looked up, before any decode.

A lookup is purely combinational from the stored table. A tag match with a counter of 2 or 3 yields the stored target. Any other lookup yields the fetch address plus one. When a branch resolves later in the pipe, an update port reports its address, its outcome and its target. On a hit the counter moves toward the outcome. On a miss the slot is claimed only for a taken branch, with the counter starting at 2. Two bits of hysteresis mean a loop-closing branch costs one wrong guess per loop exit, not two.

Top module: `branch_dir_predictor`

## Requirements
- R1: After reset every slot is empty. Any lookup then gives pred_hit=0, pred_taken=0 and pred_next equal to the looked-up address plus one.
- R2: A not-taken update that misses the table changes no slot. A slot whose entry the update did not match keeps its prediction.
- R3: A taken update that misses writes the slot: valid, the new tag, the counter set to 2 and the reported target. A lookup of that address then hits and predicts taken to that target.
- R4: A taken update that hits adds one to the counter, which stops at 3. From 3, two taken updates followed by one not-taken update still leave a taken prediction.
- R5: A not-taken update that hits subtracts one from the counter, which stops at 0. From 0, one taken update leaves it not taken and a second one makes it taken.
- R6: On a hit, pred_taken is 1 exactly when the counter is 2 or 3. pred_next is the stored target when pred_taken is 1 and the address plus one otherwise, including on a hit whose counter is 0 or 1.
- R7: The slot index is address bits [IDX_W-1:0] and the tag is the remaining upper bits. An address with the same index but a different tag misses. A taken update from such an address replaces the slot, and the previous owner then misses.
- R8: When a lookup and an update address the same slot in one cycle, the lookup shows the slot's contents from before the update. The new contents are visible from the following cycle.
- R9: A taken update that hits replaces the stored target with the reported one. A not-taken update that hits keeps the stored target.
- R10: The fall-through address wraps modulo 2^PC_W, so the all-ones address yields zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | PC_W | Fetch address being looked up |
| pred_hit | output | 1 | Lookup matched a valid slot with the same tag |
| pred_taken | output | 1 | Lookup predicts a taken branch |
| pred_next | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 for taken |
| upd_target | input | PC_W | Resolved target address |

## Verification
A lookup and an update can fall in the same cycle on the same slot, and this is where a wrong read-during-write choice would appear. The bench provokes it in two ways. It drives a not-taken update for a branch whose counter sits at 2 while looking up that same branch. It also drives a taken update for an address that misses while looking that address up. In both cases it judges the lookup output in that cycle against the old contents (taken to the old target, and a miss) and again one cycle later against the new contents (fall-through, and a hit to the new target).

// File: rtl/brp_pkg.sv
// Package: shared counter type and helpers for the branch predictor.
// Assumes a 2-bit counter; values 2 and 3 mean "taken".
package brp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_INIT = 2'd2;
    localparam ctr_t CTR_MAX  = 2'd3;
    localparam ctr_t CTR_MIN  = 2'd0;

    // Move the counter one step toward the outcome, saturating at both ends.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (taken) nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
        else       nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
        return nxt;
    endfunction

    // Upper half of the counter range predicts taken.
    function automatic logic ctr_says_taken(input ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/brp_store.sv
// Module: direct-mapped slot storage, one write port and two combinational
// read ports (fetch lookup and update read-modify-write).
// Assumes: synchronous active-low reset clears every slot; a read in the cycle
// of a write returns the value held before that write.
module brp_store #(
    parameter int PC_W  = 16,
    parameter int IDX_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      lk_idx,
    output logic                  lk_valid,
    output logic [PC_W-IDX_W-1:0] lk_tag,
    output brp_pkg::ctr_t         lk_ctr,
    output logic [PC_W-1:0]       lk_tgt,
    input  logic [IDX_W-1:0]      up_idx,
    output logic                  up_valid,
    output logic [PC_W-IDX_W-1:0] up_tag,
    output brp_pkg::ctr_t         up_ctr,
    output logic [PC_W-1:0]       up_tgt,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic                  wr_valid,
    input  logic [PC_W-IDX_W-1:0] wr_tag,
    input  brp_pkg::ctr_t         wr_ctr,
    input  logic [PC_W-1:0]       wr_tgt
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = PC_W - IDX_W;

    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [DEPTH];
    brp_pkg::ctr_t    ctr_q [DEPTH];
    logic [PC_W-1:0]  tgt_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(g));

        // Hold one slot; load it when the write port selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                tag_q[g]   <= '0;
                ctr_q[g]   <= brp_pkg::CTR_MIN;
                tgt_q[g]   <= '0;
            end else if (sel) begin
                valid_q[g] <= wr_valid;
                tag_q[g]   <= wr_tag;
                ctr_q[g]   <= wr_ctr;
                tgt_q[g]   <= wr_tgt;
            end
        end
    end

    // Fetch-side read port.
    always_comb begin
        lk_valid = valid_q[lk_idx];
        lk_tag   = tag_q[lk_idx];
        lk_ctr   = ctr_q[lk_idx];
        lk_tgt   = tgt_q[lk_idx];
    end

    // Update-side read port.
    always_comb begin
        up_valid = valid_q[up_idx];
        up_tag   = tag_q[up_idx];
        up_ctr   = ctr_q[up_idx];
        up_tgt   = tgt_q[up_idx];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_idx)] == $past(wr_valid)) &&
                  (ctr_q[$past(wr_idx)] == $past(wr_ctr)) &&
                  (tgt_q[$past(wr_idx)] == $past(wr_tgt))); // R8

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(valid_q)); // R2

endmodule

// File: rtl/brp_update.sv
// Module: turns a resolved branch plus the slot's current contents into a
// slot write. Hit: step counter, refresh target when taken. Miss: claim the
// slot only for a taken branch, counter starting at CTR_INIT.
// Assumes: old_* come from the same slot the update address indexes.
module brp_update #(
    parameter int PC_W  = 16,
    parameter int IDX_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd_valid,
    input  logic [PC_W-1:0]       upd_pc,
    input  logic                  upd_taken,
    input  logic [PC_W-1:0]       upd_target,
    input  logic                  old_valid,
    input  logic [PC_W-IDX_W-1:0] old_tag,
    input  brp_pkg::ctr_t         old_ctr,
    input  logic [PC_W-1:0]       old_tgt,
    output logic [IDX_W-1:0]      up_idx,
    output logic                  wr_en,
    output logic [IDX_W-1:0]      wr_idx,
    output logic                  wr_valid,
    output logic [PC_W-IDX_W-1:0] wr_tag,
    output brp_pkg::ctr_t         wr_ctr,
    output logic [PC_W-1:0]       wr_tgt
);
    localparam int TAG_W = PC_W - IDX_W;

    logic [TAG_W-1:0] upd_tag;
    logic             old_hit;

    assign up_idx  = upd_pc[IDX_W-1:0];
    assign upd_tag = upd_pc[PC_W-1:IDX_W];
    assign old_hit = old_valid && (old_tag == upd_tag);
    assign wr_idx  = up_idx;

    // Choose the slot write for this resolved branch.
    always_comb begin
        wr_en    = 1'b0;
        wr_valid = old_valid;
        wr_tag   = old_tag;
        wr_ctr   = old_ctr;
        wr_tgt   = old_tgt;
        if (upd_valid && old_hit) begin
            wr_en  = 1'b1;
            wr_ctr = brp_pkg::ctr_step(old_ctr, upd_taken);
            if (upd_taken) wr_tgt = upd_target;
        end else if (upd_valid && upd_taken) begin
            wr_en    = 1'b1;
            wr_valid = 1'b1;
            wr_tag   = upd_tag;
            wr_ctr   = brp_pkg::CTR_INIT;
            wr_tgt   = upd_target;
        end
    end

    AST_CTR_TOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && old_hit && upd_taken && old_ctr == brp_pkg::CTR_MAX)
            |-> (wr_en && wr_ctr == brp_pkg::CTR_MAX)); // R4

    AST_CTR_FLOOR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && old_hit && !upd_taken && old_ctr == brp_pkg::CTR_MIN)
            |-> (wr_en && wr_ctr == brp_pkg::CTR_MIN)); // R5

    AST_CLAIM_ONLY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !old_hit) |-> (upd_taken && wr_ctr == brp_pkg::CTR_INIT)); // R3

endmodule

// File: rtl/brp_lookup.sv
// Module: fetch-side decision. Compares the indexed slot's tag with the
// fetch address and picks stored target or fall-through.
// Assumes: slot fields belong to the index taken from pc.
module brp_lookup #(
    parameter int PC_W  = 16,
    parameter int IDX_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PC_W-1:0]       pc,
    output logic [IDX_W-1:0]      idx,
    input  logic                  s_valid,
    input  logic [PC_W-IDX_W-1:0] s_tag,
    input  brp_pkg::ctr_t         s_ctr,
    input  logic [PC_W-1:0]       s_tgt,
    output logic                  hit,
    output logic                  taken,
    output logic [PC_W-1:0]       next_pc
);
    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    logic [PC_W-1:0] fall_pc;

    assign idx     = pc[IDX_W-1:0];
    assign fall_pc = pc + ONE;

    // Form the prediction from the indexed slot.
    always_comb begin
        hit     = s_valid && (s_tag == pc[PC_W-1:IDX_W]);
        taken   = hit && brp_pkg::ctr_says_taken(s_ctr);
        next_pc = taken ? s_tgt : fall_pc;
    end

    AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (s_valid && s_ctr >= brp_pkg::CTR_INIT)); // R6

    AST_FIRST_AFTER_RESET_MISS: assert property (@(posedge clk)
        $rose(rst_n) |-> !hit); // R1

endmodule

// File: rtl/branch_dir_predictor.sv
// Module: top of the branch predictor. Wires slot storage, the fetch lookup
// and the resolution update together.
// Assumes: one lookup and at most one update per cycle; synchronous
// active-low reset.
module branch_dir_predictor #(
    parameter int PC_W  = 16,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_next,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);
    localparam int TAG_W = PC_W - IDX_W;

    logic [IDX_W-1:0] lk_idx, up_idx, wr_idx;
    logic             lk_valid, up_valid, wr_en, wr_valid;
    logic [TAG_W-1:0] lk_tag, up_tag, wr_tag;
    brp_pkg::ctr_t    lk_ctr, up_ctr, wr_ctr;
    logic [PC_W-1:0]  lk_tgt, up_tgt, wr_tgt;

    brp_store #(.PC_W(PC_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag),
        .lk_ctr(lk_ctr), .lk_tgt(lk_tgt),
        .up_idx(up_idx), .up_valid(up_valid), .up_tag(up_tag),
        .up_ctr(up_ctr), .up_tgt(up_tgt),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_tag(wr_tag), .wr_ctr(wr_ctr), .wr_tgt(wr_tgt)
    );

    brp_lookup #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lookup (
        .clk(clk), .rst_n(rst_n), .pc(lk_pc), .idx(lk_idx),
        .s_valid(lk_valid), .s_tag(lk_tag), .s_ctr(lk_ctr), .s_tgt(lk_tgt),
        .hit(pred_hit), .taken(pred_taken), .next_pc(pred_next)
    );

    brp_update #(.PC_W(PC_W), .IDX_W(IDX_W)) u_update (
        .clk(clk), .rst_n(rst_n),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target),
        .old_valid(up_valid), .old_tag(up_tag), .old_ctr(up_ctr), .old_tgt(up_tgt),
        .up_idx(up_idx), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_tag(wr_tag), .wr_ctr(wr_ctr), .wr_tgt(wr_tgt)
    );

endmodule

// File: tb/branch_dir_predictor_tb.sv
module branch_dir_predictor_tb;
    localparam int PC_W    = 16;
    localparam int IDX_W   = 4;
    localparam int CLK_PER = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            pred_hit, pred_taken;
    logic [PC_W-1:0] pred_next;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;
    logic [PC_W-1:0] upd_target = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    branch_dir_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_next(pred_next),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target)
    );

    task automatic chk(input string req, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Look up pc now (caller sits just after a falling edge) and compare.
    task automatic look(input string req, input logic [PC_W-1:0] pc,
                        input logic eh, input logic et, input logic [PC_W-1:0] en);
        lk_pc = pc;
        #1;
        chk({req, " hit"},   PC_W'(pred_hit),   PC_W'(eh));
        chk({req, " taken"}, PC_W'(pred_taken), PC_W'(et));
        chk({req, " next"},  pred_next, en);
    endtask

    // One update cycle; returns at the falling edge after the write edge.
    task automatic upd(input logic [PC_W-1:0] pc, input logic t, input logic [PC_W-1:0] tgt);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = t; upd_target = tgt;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic t_reset;
        look("R1 empty", 16'h0005, 1'b0, 1'b0, 16'h0006);
        look("R1 empty2", 16'h1234, 1'b0, 1'b0, 16'h1235);
    endtask

    task automatic t_alloc;
        upd(16'h0013, 1'b0, 16'h0200);
        look("R2 nt miss no claim", 16'h0013, 1'b0, 1'b0, 16'h0014);
        upd(16'h0013, 1'b1, 16'h0200);
        look("R3 claim", 16'h0013, 1'b1, 1'b1, 16'h0200);
    endtask

    task automatic t_sat_up;
        upd(16'h0013, 1'b1, 16'h0200);   // 3
        upd(16'h0013, 1'b1, 16'h0200);   // stays 3
        upd(16'h0013, 1'b0, 16'h0200);   // 2
        look("R4 top saturation", 16'h0013, 1'b1, 1'b1, 16'h0200);
        upd(16'h0013, 1'b0, 16'h0200);   // 1
        look("R6 weak hit falls through", 16'h0013, 1'b1, 1'b0, 16'h0014);
    endtask

    task automatic t_sat_down;
        upd(16'h0013, 1'b0, 16'h0200);   // 0
        upd(16'h0013, 1'b0, 16'h0200);   // stays 0
        upd(16'h0013, 1'b1, 16'h0200);   // 1
        look("R5 floor saturation", 16'h0013, 1'b1, 1'b0, 16'h0014);
        upd(16'h0013, 1'b1, 16'h0200);   // 2
        look("R5 recover", 16'h0013, 1'b1, 1'b1, 16'h0200);
    endtask

    task automatic t_tag;
        look("R7 alias miss", 16'h0023, 1'b0, 1'b0, 16'h0024);
        upd(16'h0023, 1'b0, 16'h0400);
        look("R2 other slot kept", 16'h0013, 1'b1, 1'b1, 16'h0200);
        upd(16'h0023, 1'b1, 16'h0400);
        look("R7 replace new", 16'h0023, 1'b1, 1'b1, 16'h0400);
        look("R7 replace old", 16'h0013, 1'b0, 1'b0, 16'h0014);
    endtask

    task automatic t_target;
        upd(16'h0023, 1'b1, 16'h0500);   // 3, new target
        look("R9 taken refresh", 16'h0023, 1'b1, 1'b1, 16'h0500);
        upd(16'h0023, 1'b0, 16'h0777);   // 2, target kept
        look("R9 nt keeps target", 16'h0023, 1'b1, 1'b1, 16'h0500);
    endtask

    task automatic t_same_cycle;
        upd(16'h0047, 1'b1, 16'h0100);   // slot 7 counter 2
        upd_valid = 1'b1; upd_pc = 16'h0047; upd_taken = 1'b0; upd_target = 16'h0000;
        look("R8 old view", 16'h0047, 1'b1, 1'b1, 16'h0100);
        @(negedge clk);
        upd_valid = 1'b0;
        look("R8 new view", 16'h0047, 1'b1, 1'b0, 16'h0048);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = 16'h0058; upd_taken = 1'b1; upd_target = 16'h0300;
        look("R8 claim old view", 16'h0058, 1'b0, 1'b0, 16'h0059);
        @(negedge clk);
        upd_valid = 1'b0;
        look("R8 claim new view", 16'h0058, 1'b1, 1'b1, 16'h0300);
    endtask

    task automatic t_wrap;
        look("R10 wrap", 16'hFFFF, 1'b0, 1'b0, 16'h0000);
        upd(16'hFFFF, 1'b1, 16'h0010);
        look("R10 top slot taken", 16'hFFFF, 1'b1, 1'b1, 16'h0010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_alloc();
        t_sat_up();
        t_sat_down();
        t_tag();
        t_target();
        t_same_cycle();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule